// File: doc/BRIEF.md
# Decimal Page Table Address Translator

The block maps a virtual address onto a physical one through a small page table held on chip. Addresses are written in binary-coded decimal. A virtual address has six digits. The three upper digits name a virtual page and the three lower digits give an offset inside that page. This gives 1000 virtual pages of 1000 locations each. Each table slot holds a mapped flag and a 3-bit frame index, so eight physical frames can be reached.

A lookup is presented for one cycle with a strobe. One clock edge later the block returns one of three results:
- the frame index, written as three decimal digits, followed by the offset exactly as it arrived;
- a page fault, when the page has no mapping;
- an address error, when any digit of the address is outside 0 to 9.

A separate write port lets software install a mapping or remove one, one slot per cycle. Fault service, choice of a victim page and transfers to backing store are handled elsewhere.

Top module: `bcd_page_xlat`

## Requirements
- R1: After reset no response is pending (`rsp_valid` low), and every page is unmapped, so any well-formed lookup faults until a mapping is installed. A reset that arrives while a lookup is in flight removes that lookup.
- R2: A lookup strobed at clock edge N is answered in the cycle after edge N. When the page is mapped, the answer is `rsp_paddr` = three frame digits (two zero digits, then the frame index 0..7 in the low digit of that group) followed by the offset digits unchanged, with `rsp_fault` and `rsp_bad` low. Example: page 004 mapped to frame 5, and 004006 gives 005006.
- R3: A well-formed lookup on an unmapped page answers with `rsp_fault` high.
- R4: A fault response and an error response each carry `rsp_paddr` = 0, and `rsp_fault` and `rsp_bad` are never high together.
- R5: A write with `wr_valid`=1 maps `wr_page` to `wr_frame`. A write with `wr_valid`=0 unmaps it. The change is seen by lookups from the next cycle on.
- R6: A lookup in the same cycle as a write to the same page returns the slot's contents from before that write.
- R7: If any of the six lookup digits (4 bits each, page digits in bits 23:12, offset in 11:0) is above 9, the response has `rsp_bad` high, `rsp_fault` low and `rsp_paddr` = 0, whatever the table holds.
- R8: A write whose page number contains a digit above 9 changes no slot.
- R9: In a cycle after an edge with no lookup strobe, `rsp_valid`, `rsp_fault`, `rsp_bad` and `rsp_paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup strobe |
| lk_vaddr | input | 24 | Virtual address, six BCD digits, page digits on top |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 12 | Page number to update, three BCD digits |
| wr_frame | input | 3 | Frame index to store |
| wr_valid | input | 1 | 1 installs the mapping, 0 removes it |
| rsp_valid | output | 1 | Response strobe, one cycle after `lk_req` |
| rsp_paddr | output | 24 | Physical address, six BCD digits |
| rsp_fault | output | 1 | Page not mapped |
| rsp_bad | output | 1 | Lookup address held a non-decimal digit |

## Verification
The hardest case to set up is a write and a lookup to the same page landing on the same clock edge. The bench drives both in one vector and expects the mapping that was in place before the edge. It then looks the page up again, alone, and expects the new mapping. A second hard case is a write with an illegal page digit. Under a plain weighted-sum conversion, page 00A would alias to page 010. The bench makes such a write and then reads page 010 through a normal lookup, to show the page is still unmapped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int FRAME_W = 3;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

endpackage

// File: rtl/bcd_to_bin.sv
// Converts a string of BCD digits to binary, and flags any digit above nine.
module bcd_to_bin #(
    parameter int DIGITS = 3,
    parameter int BIN_W  = 10
) (
    input  logic [4*DIGITS-1:0] bcd,
    output logic [BIN_W-1:0]    bin,
    output logic                bad
);

    logic [DIGITS-1:0] digit_bad;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign digit_bad[g] = bcd[4*g +: 4] > 4'd9;
    end

    assign bad = |digit_bad;

    always_comb begin
        int acc;
        acc = 0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(bcd[4*i +: 4]);
        end
        bin = BIN_W'(acc);
    end

endmodule

// File: rtl/page_table.sv
// Page table storage: one write port, one combinational read port.
// A read in the same cycle as a write returns the contents before the write.
module page_table #(
    parameter int DEPTH = 1000,
    parameter int IDX_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  xlat_pkg::pte_t      wr_entry,
    input  logic [IDX_W-1:0]    rd_idx,
    output xlat_pkg::pte_t      rd_entry
);

    xlat_pkg::pte_t slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            slot_q[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = (int'(rd_idx) < DEPTH) ? slot_q[rd_idx] : '0;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < DEPTH)) |=> slot_q[$past(wr_idx)] == $past(wr_entry)); // R5

endmodule

// File: rtl/bcd_page_xlat.sv
module bcd_page_xlat #(
    parameter int PAGE_DIGITS = 3,
    parameter int OFF_DIGITS  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  lk_req,
    input  logic [4*(PAGE_DIGITS+OFF_DIGITS)-1:0] lk_vaddr,
    input  logic                                  wr_en,
    input  logic [4*PAGE_DIGITS-1:0]              wr_page,
    input  logic [xlat_pkg::FRAME_W-1:0]          wr_frame,
    input  logic                                  wr_valid,
    output logic                                  rsp_valid,
    output logic [4*(PAGE_DIGITS+OFF_DIGITS)-1:0] rsp_paddr,
    output logic                                  rsp_fault,
    output logic                                  rsp_bad
);

    localparam int PG_W  = 4 * PAGE_DIGITS;
    localparam int OFF_W = 4 * OFF_DIGITS;
    localparam int VA_W  = PG_W + OFF_W;
    localparam int DEPTH = 10 ** PAGE_DIGITS;
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] paddr;
        logic            fault;
        logic            bad;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    // Lookup page decode and legality
    logic [IDX_W-1:0]      lk_idx;
    logic                  lk_page_bad;
    logic [OFF_DIGITS-1:0] off_bad;
    logic                  lk_bad;

    bcd_to_bin #(.DIGITS(PAGE_DIGITS), .BIN_W(IDX_W)) u_lk_conv (
        .bcd (lk_vaddr[VA_W-1 -: PG_W]),
        .bin (lk_idx),
        .bad (lk_page_bad)
    );

    for (genvar g = 0; g < OFF_DIGITS; g++) begin : g_off
        assign off_bad[g] = lk_vaddr[4*g +: 4] > 4'd9;
    end

    assign lk_bad = lk_page_bad || (|off_bad);

    // Write page decode; illegal page numbers never reach the table
    logic [IDX_W-1:0] wr_idx;
    logic             wr_page_bad;
    logic             tbl_we;
    xlat_pkg::pte_t   wr_entry;

    bcd_to_bin #(.DIGITS(PAGE_DIGITS), .BIN_W(IDX_W)) u_wr_conv (
        .bcd (wr_page),
        .bin (wr_idx),
        .bad (wr_page_bad)
    );

    assign tbl_we         = wr_en && !wr_page_bad;
    assign wr_entry.valid = wr_valid;
    assign wr_entry.frame = wr_frame;

    // Table
    logic [IDX_W-1:0] rd_idx;
    xlat_pkg::pte_t   rd_entry;

    assign rd_idx = lk_bad ? '0 : lk_idx;

    page_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    // Frame index rendered as decimal digits
    logic [PG_W-1:0] frame_bcd;

    always_comb begin
        int v;
        v = int'(rd_entry.frame);
        for (int i = 0; i < PAGE_DIGITS; i++) begin
            frame_bcd[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
    end

    // Next response
    always_comb begin
        rsp_d = '0;
        if (lk_req) begin
            rsp_d.valid = 1'b1;
            if (lk_bad) begin
                rsp_d.bad = 1'b1;
            end else if (!rd_entry.valid) begin
                rsp_d.fault = 1'b1;
            end else begin
                rsp_d.paddr = {frame_bcd, lk_vaddr[OFF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;
    assign rsp_bad   = rsp_q.bad;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_fault && !rsp_bad && rsp_paddr == '0)); // R9
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_bad) |-> (rsp_paddr == '0 && !(rsp_fault && rsp_bad))); // R4
    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (lk_page_bad || (|off_bad))) |=> rsp_bad); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_fault || rsp_bad
                    || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R2

endmodule

// File: tb/sim_bcd_page_xlat.sv
`timescale 1ns/1ps
module sim_bcd_page_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [23:0] lk_vaddr = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_page = '0;
    logic [2:0]  wr_frame = '0;
    logic        wr_valid = 1'b0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_bad;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bcd_page_xlat u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .wr_en(wr_en), .wr_page(wr_page), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_bad(rsp_bad)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] wpage;
        logic [2:0]  wfr;
        logic        wv;
        logic        lk;
        logic [23:0] va;
        logic [23:0] ep;
        logic        ef;
        logic        eb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h004006, 24'h000000, 1'b1, 1'b0, 4'd1}, // R1 empty table faults
        '{1'b1, 12'h004, 3'd5, 1'b1, 1'b0, 24'h000000, 24'h000000, 1'b0, 1'b0, 4'd9}, // R9 write only, quiet
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h004006, 24'h005006, 1'b0, 1'b0, 4'd2}, // R2 example
        '{1'b1, 12'h999, 3'd7, 1'b1, 1'b0, 24'h000000, 24'h000000, 1'b0, 1'b0, 4'd9}, // R9
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h999999, 24'h007999, 1'b0, 1'b0, 4'd2}, // R2 top page
        '{1'b1, 12'h000, 3'd0, 1'b1, 1'b1, 24'h000000, 24'h000000, 1'b1, 1'b0, 4'd6}, // R6 old = unmapped
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h000000, 24'h000000, 1'b0, 1'b0, 4'd5}, // R5 page 0 -> frame 0
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h123456, 24'h000000, 1'b1, 1'b0, 4'd3}, // R3 R4
        '{1'b1, 12'h004, 3'd2, 1'b1, 1'b1, 24'h004321, 24'h005321, 1'b0, 1'b0, 4'd6}, // R6 old frame 5
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h004321, 24'h002321, 1'b0, 1'b0, 4'd5}, // R5 remap
        '{1'b1, 12'h004, 3'd0, 1'b0, 1'b0, 24'h000000, 24'h000000, 1'b0, 1'b0, 4'd9}, // R9 unmap write
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h004000, 24'h000000, 1'b1, 1'b0, 4'd5}, // R5 unmapped now
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h00A000, 24'h000000, 1'b0, 1'b1, 4'd7}, // R7 page digit
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h99900C, 24'h000000, 1'b0, 1'b1, 4'd7}, // R7 offset digit
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'hF00000, 24'h000000, 1'b0, 1'b1, 4'd7}, // R7 R4
        '{1'b1, 12'h00A, 3'd3, 1'b1, 1'b1, 24'h010555, 24'h000000, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h010555, 24'h000000, 1'b1, 1'b0, 4'd8}, // R8 no alias
        '{1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 24'h999999, 24'h007999, 1'b0, 1'b0, 4'd8}  // R8 others intact
    };

    task automatic check(input logic v, input logic [23:0] p, input logic f, input logic b,
                         input int req);
        checks++;
        if (rsp_valid !== v || rsp_paddr !== p || rsp_fault !== f || rsp_bad !== b) begin
            errors++;
            $display("FAIL R%0d: got valid=%b paddr=%h fault=%b bad=%b, expected valid=%b paddr=%h fault=%b bad=%b",
                     req, rsp_valid, rsp_paddr, rsp_fault, rsp_bad, v, p, f, b);
        end
    endtask

    task automatic clear_inputs();
        lk_req = 1'b0; lk_vaddr = '0; wr_en = 1'b0; wr_page = '0; wr_frame = '0; wr_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 24'h0, 1'b0, 1'b0, 1); // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we; wr_page = VEC[i].wpage; wr_frame = VEC[i].wfr; wr_valid = VEC[i].wv;
            lk_req = VEC[i].lk; lk_vaddr = VEC[i].va;
            @(negedge clk);
            clear_inputs();
            check(VEC[i].lk, VEC[i].ep, VEC[i].ef, VEC[i].eb, int'(VEC[i].req));
        end

        // R9: idle cycle after a lookup returns to zero
        @(negedge clk);
        check(1'b0, 24'h0, 1'b0, 1'b0, 9);

        // R1: reset while a lookup is in flight discards it and clears the table
        lk_req = 1'b1; lk_vaddr = 24'h999000;
        #2 rst_n = 1'b0;
        @(negedge clk);
        clear_inputs();
        check(1'b0, 24'h0, 1'b0, 1'b0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = 24'h999000;
        @(negedge clk);
        clear_inputs();
        check(1'b1, 24'h0, 1'b1, 1'b0, 1); // R1 mapping gone

        // R5 R2: frame 7 on page 000 after reset, back-to-back lookups
        wr_en = 1'b1; wr_page = 12'h000; wr_frame = 3'd7; wr_valid = 1'b1;
        @(negedge clk);
        clear_inputs();
        lk_req = 1'b1; lk_vaddr = 24'h000999;
        @(negedge clk);
        check(1'b1, 24'h007999, 1'b0, 1'b0, 5);
        lk_vaddr = 24'h001999;
        @(negedge clk);
        clear_inputs();
        check(1'b1, 24'h0, 1'b1, 1'b0, 3); // R3

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule